// File: doc/BRIEF.md
# Normalizing Sequential Unsigned Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor and returns a W-bit quotient and a W-bit remainder. It makes one quotient bit per clock with a restoring shift-left partial remainder. When a start pulse is accepted, the block counts the divisor's leading zeros (s). It shifts the divisor left by s so that its top bit is set, and then runs only s + 1 compare-and-subtract steps instead of a fixed W.

The partial remainder begins as the dividend itself, which is the top W bits of the dividend padded with s zero bits on the right. Every later step shifts in one of those zeros. The raw remainder that is left at the end carries a factor of 2^s. A final stage shifts it right by s and publishes both results with a one-cycle done pulse.

A zero divisor never iterates. It finishes on the accepting edge with an all-ones quotient, the remainder equal to the dividend, and a divide-by-zero flag.

Top module: `div_norm`

## Requirements
- R1: For a non-zero divisor V and dividend D, the results satisfy D = V*Q + R with R < V, where Q and R are the plain unsigned quotient and remainder.
- R2: The shift amount s is the number of leading zero bits of V within W bits. The working divisor is V shifted left by s and has its top bit set throughout iteration.
- R3: For V != 0, done_o rises on the (s+2)-th rising edge after the edge that samples start_i. busy_o is high from that sampling edge until the edge that raises done_o.
- R4: Each step sets a quotient bit of 1 and subtracts when the window is at least the working divisor, and otherwise sets 0 with no subtraction. The s+1 quotient bits are zero-extended to W bits.
- R5: At the start of every step the partial-remainder window is less than twice the working divisor.
- R6: The remainder output is the final window shifted right by s.
- R7: done_o is high for exactly one cycle while busy_o is low. quotient_o, remainder_o and dbz_o hold their values until the next completion.
- R8: A start_i pulse while busy_o is high, including the final busy cycle, is ignored and does not change the running operation or its result.
- R9: With V = 0, done_o rises on the edge that samples start_i. quotient_o is then all ones, remainder_o equals D and dbz_o is 1. For V != 0, dbz_o is 0 on completion.
- R10: While rst_ni is low, busy_o, done_o, dbz_o, quotient_o and remainder_o are 0, and any operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| dividend_i | input | W | Dividend D, sampled with start_i |
| divisor_i | input | W | Divisor V, sampled with start_i |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Last result came from a zero divisor |
| quotient_o | output | W | Quotient Q |
| remainder_o | output | W | Remainder R |

## Verification
Accepting a new start and finishing the current division can land in the same cycle, and two cases test this. In the first, the next start is driven in the very cycle that done_o is high. The block is already idle there, so it must take the new operands and deliver a correct result exactly s+2 edges later. In the second, a start with other operands is pulsed during the final denormalize cycle, while busy_o is still high. That start must be dropped: the bench checks that the original result appears on time, and that busy_o stays low in the cycle after done.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_lzc.sv
module div_lzc #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [SW-1:0] cnt_o,
  output logic          zero_o
);
  logic hit;

  always_comb begin
    cnt_o = '0;
    hit   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (val_i[i]) hit = 1'b1;
        else          cnt_o = cnt_o + SW'(1);
      end
    end
  end

  assign zero_o = ~|val_i;

  always_comb begin
    if (!zero_o) a_r2_lzc_norm: assert ((val_i << cnt_o) >= (W'(1) << (W - 1)));
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 16
) (
  input  logic [W:0]   win_i,
  input  logic [W-1:0] div_i,
  input  logic         last_i,
  output logic         qbit_o,
  output logic [W:0]   win_o
);
  logic [W:0] rest;

  always_comb begin
    qbit_o = (win_i >= {1'b0, div_i});
    rest   = qbit_o ? (win_i - {1'b0, div_i}) : win_i;
    // last step keeps the raw remainder unshifted
    win_o  = last_i ? rest : {rest[W-1:0], 1'b0};
  end
endmodule

// File: rtl/div_fsm.sv
module div_fsm
  import div_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          zero_i,
  input  logic [SW-1:0] shift_i,
  output logic          load_o,
  output logic          zdone_o,
  output logic          iter_o,
  output logic          last_o,
  output logic          fix_o,
  output logic          busy_o
);
  div_state_e   state_q;
  logic [SW-1:0] cnt_q;

  assign load_o  = (state_q == ST_IDLE) && start_i && !zero_i;
  assign zdone_o = (state_q == ST_IDLE) && start_i && zero_i;
  assign iter_o  = (state_q == ST_RUN);
  assign last_o  = iter_o && (cnt_q == '0);
  assign fix_o   = (state_q == ST_FIX);
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= shift_i;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIX;
          else             cnt_q   <= cnt_q - SW'(1);
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_run_exits_to_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> fix_o);
  a_r8_no_load_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_o && !zdone_o);
endmodule

// File: rtl/div_norm.sv
module div_norm #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dbz_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  logic [SW-1:0] lz;
  logic          v_zero;
  logic          load, zdone, iter, last, fix;
  logic [W:0]    win_q, win_nx;
  logic [W-1:0]  dn_q, q_sh;
  logic [SW-1:0] sh_q;
  logic          qbit;

  div_lzc #(.W(W), .SW(SW)) u_lzc (
    .val_i (divisor_i),
    .cnt_o (lz),
    .zero_o(v_zero)
  );

  div_fsm #(.W(W), .SW(SW)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .zero_i (v_zero),
    .shift_i(lz),
    .load_o (load),
    .zdone_o(zdone),
    .iter_o (iter),
    .last_o (last),
    .fix_o  (fix),
    .busy_o (busy_o)
  );

  div_step #(.W(W)) u_step (
    .win_i (win_q),
    .div_i (dn_q),
    .last_i(last),
    .qbit_o(qbit),
    .win_o (win_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      dn_q  <= '0;
      sh_q  <= '0;
      q_sh  <= '0;
    end else if (load) begin
      win_q <= {1'b0, dividend_i};
      dn_q  <= divisor_i << lz;
      sh_q  <= lz;
      q_sh  <= '0;
    end else if (iter) begin
      win_q <= win_nx;
      q_sh  <= {q_sh[W-2:0], qbit};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      dbz_o       <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
    end else begin
      done_o <= fix || zdone;
      if (fix) begin
        quotient_o  <= q_sh;
        remainder_o <= win_q[W-1:0] >> sh_q;  // undo normalization
        dbz_o       <= 1'b0;
      end else if (zdone) begin
        quotient_o  <= '1;
        remainder_o <= dividend_i;
        dbz_o       <= 1'b1;
      end
    end
  end

  a_r1_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dbz_o) |-> (remainder_o < (dn_q >> sh_q)));
  a_r2_divisor_normalized: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter |-> dn_q[W-1]);
  a_r5_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter |-> (win_q < {dn_q, 1'b0}));
  a_r7_done_while_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r3_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r8_operands_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dn_q) && $stable(sh_q));
  a_r9_dbz_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbz_o) |-> done_o && (&quotient_o));
endmodule

// File: tb/sim_div_norm.sv
`timescale 1ns/1ps
module sim_div_norm;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done, dbz;
  logic [W-1:0] quo, rem;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  div_norm #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .dividend_i(dividend), .divisor_i(divisor),
    .busy_o(busy), .done_o(done), .dbz_o(dbz),
    .quotient_o(quo), .remainder_o(rem)
  );

  // {dividend, divisor, quotient, remainder}
  localparam logic [63:0] VEC [10] = '{
    {16'd29,    16'd4,     16'd7,     16'd1},
    {16'd65535, 16'd1,     16'd65535, 16'd0},
    {16'd65535, 16'd65535, 16'd1,     16'd0},
    {16'd0,     16'd5,     16'd0,     16'd0},
    {16'd100,   16'd7,     16'd14,    16'd2},
    {16'd32768, 16'd32768, 16'd1,     16'd0},
    {16'd12345, 16'd256,   16'd48,    16'd57},
    {16'd5,     16'd9,     16'd0,     16'd5},
    {16'd65535, 16'd32768, 16'd1,     16'd32767},
    {16'd777,   16'd0,     16'd65535, 16'd777}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lead_zeros(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return W - 1 - i;
    return W;
  endfunction

  // drive start at a negedge; returns at the negedge where done is seen
  task automatic run_div(input logic [W-1:0] d, input logic [W-1:0] v);
    int e;
    int exp_lat;
    logic [W-1:0] eq, er;
    dividend = d; divisor = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    if (v != 0) chk("R3 busy after start", busy, 1);
    while (!done && e < 40) begin
      @(negedge clk);
      e++;
    end
    if (v == 0) begin
      eq = '1; er = d; exp_lat = 0;
    end else begin
      eq = d / v; er = d % v; exp_lat = lead_zeros(v) + 2;
    end
    chk("R3 latency", e, exp_lat);
    chk("R1 R4 quotient", quo, eq);
    chk("R1 R6 remainder", rem, er);
    chk("R9 dbz flag", dbz, (v == 0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 0);
    chk("R10 done in reset", done, 0);
    chk("R10 quotient in reset", quo, 0);
    chk("R10 remainder in reset", rem, 0);
    chk("R10 dbz in reset", dbz, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < 10; i++) begin
      run_div(VEC[i][63:48], VEC[i][47:32]);
      chk("R1 table quotient", quo, VEC[i][31:16]);
      chk("R6 table remainder", rem, VEC[i][15:0]);
    end

    // R7: done is a single pulse, results held
    begin
      logic [W-1:0] hq, hr;
      run_div(16'd1000, 16'd7);
      hq = quo; hr = rem;
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
      chk("R7 busy low after done", busy, 0);
      repeat (3) @(negedge clk);
      chk("R7 quotient held", quo, hq);
      chk("R7 remainder held", rem, hr);
    end

    // R8: starts while busy (mid-run and final busy cycle) ignored
    begin
      int e;
      dividend = 16'd1000; divisor = 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0; e = 0;
      while (!done && e < 40) begin
        if (e == 3 || e == 15) begin
          start = 1'b1; dividend = 16'd7; divisor = 16'd0;
        end else begin
          start = 1'b0; dividend = 16'd50; divisor = 16'd7;
        end
        @(negedge clk);
        e++;
      end
      start = 1'b0;
      chk("R8 latency unchanged", e, 16);
      chk("R8 quotient unchanged", quo, 333);
      chk("R8 remainder unchanged", rem, 1);
      chk("R8 dbz unchanged", dbz, 0);
      @(negedge clk);
      chk("R8 no launch from final-cycle start", busy, 0);
      chk("R8 no extra done", done, 0);
    end

    // exhaustive 6-bit operands, back-to-back starts in the done cycle (R2 R5)
    for (int d = 0; d < 64; d++)
      for (int v = 0; v < 64; v++)
        run_div(W'(d), W'(v));

    // random full-width operands
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] rd, rv;
      rd = W'($urandom);
      rv = W'($urandom >> (k % 16));
      run_div(rd, rv);
    end

    // R10: reset abandons a running division
    dividend = 16'd60000; divisor = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 busy cleared by reset", busy, 0);
    chk("R10 quotient cleared by reset", quo, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 no done after abandoned run", done, 0);
    run_div(16'd60000, 16'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule